// File: doc/BRIEF.md
# Partition Routing Crosspoint Switch

This block lets several independently run partitions share one set of timing-distribution outputs. It takes a small number of timing-source inputs, one per partition master, and drives sixteen distribution outputs. Each output has a route entry that names the single source it follows, so any group of outputs can be given to any one source. Route entries are written and read back through a simple register port. Each entry holds a source index and an enable bit, and the port addresses entries by output number.

The same route entries also steer two reverse throttle paths. These paths are independent and identical. Each has one throttle input per distribution output. Every source gets back the OR of the throttle inputs on the enabled outputs routed to it, so a source is only held off by its own partition. Throttle inputs are asynchronous. They pass through a two-flop synchroniser and a registered OR, which gives a fixed latency of three clocks. A disabled output drives low and adds nothing to any reverse OR.

Top module: `xsw_top`

## Requirements
- R1: After reset every route entry reads as zero (disabled, source 0), every distribution output is low and both throttle outputs are all low.
- R2: A write with `cfg_we` high stores `cfg_wdata` into the entry for output `cfg_addr`. Bit 2 is the enable bit and bits 1:0 are the source index. The entry takes effect from the clock edge of the write.
- R3: `cfg_rdata` shows, in the same cycle, the active entry for `cfg_addr` in the same bit layout as a write.
- R4: An enabled output drives the value of the source input its entry selects. The forward path has no register.
- R5: A disabled output drives 0, whatever its source index and the source inputs are.
- R6: On each throttle path, bit s of the throttle output is the OR of the throttle inputs of every enabled output routed to source s.
- R7: A throttle input on a disabled output, or on an output routed to another source, does not affect a source's throttle output.
- R8: A change on the throttle inputs reaches the throttle outputs exactly three clock edges after it is applied, and not earlier.
- R9: The two throttle paths are independent: the inputs of one path never affect the outputs of the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 4 | Timing-source inputs, one per partition master |
| dist_out | output | 16 | Distribution outputs |
| cfg_we | input | 1 | Route entry write strobe |
| cfg_addr | input | 4 | Output number of the entry to write or read |
| cfg_wdata | input | 3 | Entry to write: {enable, source index} |
| cfg_rdata | output | 3 | Active entry at cfg_addr: {enable, source index} |
| thr_a_in | input | 16 | First throttle path inputs, one per output |
| thr_b_in | input | 16 | Second throttle path inputs, one per output |
| thr_a_out | output | 4 | First throttle path OR per source |
| thr_b_out | output | 4 | Second throttle path OR per source |

## Verification
The bench loads four route maps. One is a round-robin map and one is a scrambled map. The other two disable outputs, and in one of them every enabled output shares a single source. Under each map it sweeps all sixteen source patterns and all single-bit and mixed throttle patterns. A design that routed throttles by output index instead of by entry, or kept disabled outputs in the OR, would raise a source's throttle from another partition's input. A design with one synchroniser stage too few or too many would show the new throttle value one edge early, or still show the old value at the third edge. The second path is always driven with a different pattern, so any crossed or shared OR logic shows up as a wrong bit.

// File: rtl/xsw_pkg.sv
package xsw_pkg;

    localparam int XSW_DEF_SRCS = 4;
    localparam int XSW_DEF_OUTS = 16;
    localparam int XSW_PATHS    = 2;

    // Index width that stays at least one bit for degenerate counts.
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/xsw_route_map.sv
module xsw_route_map #(
    parameter int N_SRC = xsw_pkg::XSW_DEF_SRCS,
    parameter int N_OUT = xsw_pkg::XSW_DEF_OUTS
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic                                   cfg_we,
    input  logic [xsw_pkg::idx_w(N_OUT)-1:0]       cfg_addr,
    input  logic [xsw_pkg::idx_w(N_SRC):0]         cfg_wdata,
    output logic [xsw_pkg::idx_w(N_SRC):0]         cfg_rdata,
    output logic [N_OUT-1:0]                       out_en,
    output logic [N_OUT*xsw_pkg::idx_w(N_SRC)-1:0] out_sel
);
    localparam int SEL_W = xsw_pkg::idx_w(N_SRC);

    logic [N_OUT-1:0] en_q;
    logic [SEL_W-1:0] sel_q [N_OUT];
    logic             addr_ok;

    assign addr_ok = 32'(cfg_addr) < N_OUT;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            for (int o = 0; o < N_OUT; o++) sel_q[o] <= '0;
        end else if (cfg_we && addr_ok) begin
            en_q[cfg_addr]  <= cfg_wdata[SEL_W];
            sel_q[cfg_addr] <= cfg_wdata[SEL_W-1:0];
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (addr_ok) cfg_rdata = {en_q[cfg_addr], sel_q[cfg_addr]};
    end

    assign out_en = en_q;
    for (genvar o = 0; o < N_OUT; o++) begin : g_sel
        assign out_sel[o*SEL_W +: SEL_W] = sel_q[o];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && addr_ok) |=>
            (en_q[$past(cfg_addr)] == $past(cfg_wdata[SEL_W]) &&
             sel_q[$past(cfg_addr)] == $past(cfg_wdata[SEL_W-1:0]))); // R2
endmodule

// File: rtl/xsw_fwd_mux.sv
module xsw_fwd_mux #(
    parameter int N_SRC = xsw_pkg::XSW_DEF_SRCS,
    parameter int N_OUT = xsw_pkg::XSW_DEF_OUTS
) (
    input  logic [N_SRC-1:0]                       src_in,
    input  logic [N_OUT-1:0]                       out_en,
    input  logic [N_OUT*xsw_pkg::idx_w(N_SRC)-1:0] out_sel,
    output logic [N_OUT-1:0]                       dist_out
);
    localparam int SEL_W = xsw_pkg::idx_w(N_SRC);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [SEL_W-1:0] sel_v;
        assign sel_v = out_sel[o*SEL_W +: SEL_W];
        always_comb begin
            dist_out[o] = 1'b0;
            if (out_en[o] && 32'(sel_v) < N_SRC) dist_out[o] = src_in[sel_v];
        end
    end
endmodule

// File: rtl/xsw_thr_or.sv
module xsw_thr_or #(
    parameter int N_SRC = xsw_pkg::XSW_DEF_SRCS,
    parameter int N_OUT = xsw_pkg::XSW_DEF_OUTS
) (
    input  logic                                   clk,
    input  logic                                   rst,
    input  logic [N_OUT-1:0]                       thr_in,
    input  logic [N_OUT-1:0]                       out_en,
    input  logic [N_OUT*xsw_pkg::idx_w(N_SRC)-1:0] out_sel,
    output logic [N_SRC-1:0]                       thr_out
);
    localparam int SEL_W = xsw_pkg::idx_w(N_SRC);

    logic [N_OUT-1:0] sync1_q, sync2_q;
    logic [N_OUT-1:0] memb [N_SRC];
    logic [N_SRC-1:0] or_d, thr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1_q <= '0;
            sync2_q <= '0;
            thr_q   <= '0;
        end else begin
            sync1_q <= thr_in;
            sync2_q <= sync1_q;
            thr_q   <= or_d;
        end
    end

    // Membership of each output in each source's partition.
    always_comb begin
        for (int s = 0; s < N_SRC; s++) begin
            for (int o = 0; o < N_OUT; o++) begin
                memb[s][o] = out_en[o] &&
                             (32'(out_sel[o*SEL_W +: SEL_W]) == s);
            end
            or_d[s] = |(sync2_q & memb[s]);
        end
    end

    assign thr_out = thr_q;

    AST_THR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (|thr_q) |-> $past(|sync2_q)); // R6
endmodule

// File: rtl/xsw_top.sv
module xsw_top #(
    parameter int N_SRC = xsw_pkg::XSW_DEF_SRCS,
    parameter int N_OUT = xsw_pkg::XSW_DEF_OUTS
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic [N_SRC-1:0]                     src_in,
    output logic [N_OUT-1:0]                     dist_out,
    input  logic                                 cfg_we,
    input  logic [xsw_pkg::idx_w(N_OUT)-1:0]     cfg_addr,
    input  logic [xsw_pkg::idx_w(N_SRC):0]       cfg_wdata,
    output logic [xsw_pkg::idx_w(N_SRC):0]       cfg_rdata,
    input  logic [N_OUT-1:0]                     thr_a_in,
    input  logic [N_OUT-1:0]                     thr_b_in,
    output logic [N_SRC-1:0]                     thr_a_out,
    output logic [N_SRC-1:0]                     thr_b_out
);
    localparam int SEL_W = xsw_pkg::idx_w(N_SRC);

    logic [N_OUT-1:0]       out_en;
    logic [N_OUT*SEL_W-1:0] out_sel;
    logic [N_OUT-1:0]       thr_in_p  [xsw_pkg::XSW_PATHS];
    logic [N_SRC-1:0]       thr_out_p [xsw_pkg::XSW_PATHS];

    xsw_route_map #(.N_SRC(N_SRC), .N_OUT(N_OUT)) u_map (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .out_en(out_en), .out_sel(out_sel)
    );

    xsw_fwd_mux #(.N_SRC(N_SRC), .N_OUT(N_OUT)) u_fwd (
        .src_in(src_in), .out_en(out_en), .out_sel(out_sel), .dist_out(dist_out)
    );

    assign thr_in_p[0] = thr_a_in;
    assign thr_in_p[1] = thr_b_in;

    for (genvar p = 0; p < xsw_pkg::XSW_PATHS; p++) begin : g_path
        xsw_thr_or #(.N_SRC(N_SRC), .N_OUT(N_OUT)) u_or (
            .clk(clk), .rst(rst), .thr_in(thr_in_p[p]),
            .out_en(out_en), .out_sel(out_sel), .thr_out(thr_out_p[p])
        );
    end

    assign thr_a_out = thr_out_p[0];
    assign thr_b_out = thr_out_p[1];

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (thr_a_out == '0 && thr_b_out == '0 && dist_out == '0)); // R1

    for (genvar o = 0; o < N_OUT; o++) begin : g_chk
        AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (rst)
            !out_en[o] |-> !dist_out[o]); // R5
    end
endmodule

// File: tb/test_xsw_top.sv
module test_xsw_top;
    localparam int NS = 4;
    localparam int NO = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_in = '0;
    logic [NO-1:0] dist_out;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [2:0]    cfg_wdata = '0;
    logic [2:0]    cfg_rdata;
    logic [NO-1:0] thr_a_in = '0, thr_b_in = '0;
    logic [NS-1:0] thr_a_out, thr_b_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    int m_en [NO];
    int m_sel [NO];

    always #10 clk = ~clk;

    xsw_top i_xsw_top (
        .clk(clk), .rst(rst), .src_in(src_in), .dist_out(dist_out),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .thr_a_in(thr_a_in), .thr_b_in(thr_b_in),
        .thr_a_out(thr_a_out), .thr_b_out(thr_b_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [NO-1:0] exp_fwd(input logic [NS-1:0] s);
        logic [NO-1:0] r = '0;
        for (int o = 0; o < NO; o++) if (m_en[o] != 0) r[o] = s[m_sel[o]];
        return r;
    endfunction

    function automatic logic [NS-1:0] exp_thr(input logic [NO-1:0] t);
        logic [NS-1:0] r = '0;
        for (int o = 0; o < NO; o++) if (m_en[o] != 0 && t[o]) r[m_sel[o]] = 1'b1;
        return r;
    endfunction

    task automatic wr(input int a, input int en, input int sel);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = {1'(en), 2'(sel)};
        @(negedge clk);
        cfg_we = 1'b0;
        m_en[a] = en; m_sel[a] = sel;
    endtask

    task automatic load_map(input int m);
        for (int o = 0; o < NO; o++) begin
            case (m)
                0: wr(o, 1, o % 4);
                1: wr(o, 1, (o * 3 + 1) % 4);
                2: wr(o, (o % 3 != 0) ? 1 : 0, o / 4);
                default: wr(o, o % 2, 2);
            endcase
        end
    endtask

    function automatic logic [NO-1:0] pat(input int k);
        if (k < 16) return 16'(1 << k);
        return 16'((k * 16'h3B5) ^ (k << 9) ^ 16'hA5C3);
    endfunction

    initial begin
        logic [NS-1:0] old_a, old_b;
        for (int o = 0; o < NO; o++) begin m_en[o] = 0; m_sel[o] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1 dist_out", 32'(dist_out), 0);
        check("R1 thr_a_out", 32'(thr_a_out), 0);
        check("R1 thr_b_out", 32'(thr_b_out), 0);
        for (int o = 0; o < NO; o++) begin
            cfg_addr = 4'(o); #1;
            check("R1 entry", 32'(cfg_rdata), 0);
        end
        for (int m = 0; m < 4; m++) begin
            load_map(m);
            // R2 R3: read back every entry
            for (int o = 0; o < NO; o++) begin
                cfg_addr = 4'(o); #1;
                check("R2 R3 readback", 32'(cfg_rdata), 32'({1'(m_en[o]), 2'(m_sel[o])}));
            end
            // R4 R5: forward sweep
            for (int v = 0; v < 16; v++) begin
                src_in = 4'(v); #1;
                check("R4 R5 forward", 32'(dist_out), 32'(exp_fwd(4'(v))));
            end
            // R6..R9: throttle sweep with latency check
            thr_a_in = '0; thr_b_in = '0;
            repeat (4) @(negedge clk);
            old_a = '0; old_b = '0;
            for (int k = 0; k < 24; k++) begin
                thr_a_in = pat(k);
                thr_b_in = {pat(k)[7:0], pat(k)[15:8]} ^ 16'h00FF;
                @(posedge clk); @(posedge clk); @(negedge clk);
                check("R8 early a", 32'(thr_a_out), 32'(old_a));
                check("R8 early b", 32'(thr_b_out), 32'(old_b));
                @(negedge clk);
                check("R6 R7 thr_a", 32'(thr_a_out), 32'(exp_thr(thr_a_in)));
                check("R9 thr_b", 32'(thr_b_out), 32'(exp_thr(thr_b_in)));
                old_a = exp_thr(thr_a_in); old_b = exp_thr(thr_b_in);
                repeat (2) @(negedge clk);
            end
        end
        // R5 R7: disable one output with everything driven high
        thr_a_in = '1; thr_b_in = '0; src_in = '1;
        wr(5, 0, 1);
        repeat (4) @(negedge clk);
        check("R5 disabled out", 32'(dist_out[5]), 0);
        check("R7 disabled thr", 32'(thr_a_out), 32'(exp_thr('1)));
        check("R9 other path", 32'(thr_b_out), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule